// File: doc/BRIEF.md
# Memory Bit-Field Operation Unit

This unit carries out one bit-field operation per request on a field held in byte-addressed, big-endian memory. A field is located by a byte base address and a signed bit offset, and is between 1 and 32 bits long. The unit works out which byte holds the first bit and how many bytes the field covers. It reads those bytes one at a time over a byte-wide request/acknowledge port. For the modifying operations it then writes the changed bytes back. It returns a 32-bit result and the N and Z condition flags.

The caller supplies the operation code, base address, bit offset, length operand and, for insert, the source value, and pulses `start`. A one-cycle `done` pulse reports that the result and flags are valid. They stay unchanged until the next request completes. Instruction decoding and register access remain with the caller.

Top module: `bitfield_mem_unit`

## Requirements
- R1: The field length is the low 5 bits of `len_raw`. A value of 0 in those bits selects a length of 32, and the upper bits are ignored.
- R2: The first byte is `base_addr + floor(bit_ofs / 8)` and the starting bit is `bit_ofs mod 8` (0..7), with `bit_ofs` taken as signed. A negative offset therefore reaches back one byte further than truncation would.
- R3: Each operation reads exactly `(start_bit + length - 1) / 8 + 1` bytes (1 to 5), at ascending consecutive addresses starting at the first byte.
- R4: Field bit 0 is the most significant bit of the first byte, and the field continues through lower-order bits and then into the following bytes.
- R5: Op 0 returns the field zero-extended to 32 bits. Op 1 returns it sign-extended from its top bit.
- R6: Op 2 (insert) writes the low `length` bits of `src_val` into the field and leaves every other bit of the touched bytes unchanged. It writes back exactly the bytes it read and returns those low `length` bits zero-extended.
- R7: Op 3 inverts the field, op 4 clears it and op 5 sets it to ones. Each writes back exactly the bytes read, keeps bits outside the field, and returns the old field zero-extended.
- R8: Op 6 (find first one) writes nothing. It returns `bit_ofs` plus the number of leading zeros of the field, or `bit_ofs` plus the length when the field is zero (32-bit wraparound sum).
- R9: N equals field bit 0 before modification. For insert it is bit `length-1` of `src_val`.
- R10: Z is 1 exactly when the old field is all zeros. For insert it is 1 exactly when the inserted bits are all zeros.
- R11: All reads complete before the first write. Ops 0, 1 and 6 issue no writes. `mem_req` together with its address, write enable and data holds steady until `mem_ack`. `done` lasts one cycle, and `busy` is low only when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 3 | Operation: 0 extu, 1 exts, 2 insert, 3 change, 4 clear, 5 set, 6 find-first-one |
| base_addr | input | ADDR_W | Byte base address |
| bit_ofs | input | 32 | Signed bit offset from the base byte's MSB |
| len_raw | input | 32 | Length operand; low 5 bits used, 0 means 32 |
| src_val | input | 32 | Insert source value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Field result |
| flag_n | output | 1 | N flag |
| flag_z | output | 1 | Z flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Access accepted/completed |

## Verification
The bench builds the unit with `ADDR_W` set to 16 and backs the port with a 64-byte memory indexed by the low address bits. This makes the address parameter narrower than the offset, so the floor-based byte displacement is truncated into the address width. Negative offsets land below the base address inside a small image that can be compared byte for byte after every operation. Fields of one to five bytes, including a full 32-bit field starting at bit 7, all fit within the image.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [2:0] {
    BF_EXTU = 3'd0,
    BF_EXTS = 3'd1,
    BF_INS  = 3'd2,
    BF_CHG  = 3'd3,
    BF_CLR  = 3'd4,
    BF_SET  = 3'd5,
    BF_FFO  = 3'd6
  } bf_op_e;

  localparam int FIELD_W   = 32;
  localparam int WIN_BYTES = 5;
  localparam int WIN_W     = WIN_BYTES * 8;
  localparam int LEN_W     = $clog2(FIELD_W) + 1;

  // Low five bits of the operand; zero selects a full word.
  function automatic logic [LEN_W-1:0] decode_len(input logic [4:0] raw);
    return (raw == 5'd0) ? LEN_W'(FIELD_W) : {1'b0, raw};
  endfunction

  // Index of the last byte covered, counted from the first (0..4).
  function automatic logic [2:0] span_last(input logic [2:0] bofs, input logic [LEN_W-1:0] len);
    logic [6:0] s;
    s = {4'b0, bofs} + {1'b0, len} - 7'd1;
    return s[5:3];
  endfunction

  function automatic logic is_modify(input logic [2:0] op);
    return (op == BF_INS) || (op == BF_CHG) || (op == BF_CLR) || (op == BF_SET);
  endfunction

  function automatic logic [LEN_W-1:0] lead_zeros(input logic [FIELD_W-1:0] v);
    logic [LEN_W-1:0] cnt;
    cnt = LEN_W'(FIELD_W);
    for (int i = 0; i < FIELD_W; i++)
      if (v[i]) cnt = LEN_W'(FIELD_W - 1 - i);
    return cnt;
  endfunction

endpackage

// File: rtl/bfu_span_calc.sv
module bfu_span_calc
  import bfu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [31:0]       ofs_i,
  input  logic [31:0]       len_raw_i,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [2:0]        bofs_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [2:0]        last_o
);
  logic [31:0] disp;

  always_comb begin
    disp         = $signed(ofs_i) >>> 3;      // floor division by 8
    first_addr_o = base_i + disp[ADDR_W-1:0];
    bofs_o       = ofs_i[2:0];                // floor remainder, 0..7
    len_o        = decode_len(len_raw_i[4:0]);
    last_o       = span_last(ofs_i[2:0], len_o);
  end
endmodule

// File: rtl/bfu_field_alu.sv
module bfu_field_alu
  import bfu_pkg::*;
(
  input  logic [2:0]       op_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic [2:0]       bofs_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [31:0]      src_i,
  input  logic [31:0]      ofs_i,
  output logic [WIN_W-1:0] win_o,
  output logic [31:0]      res_o,
  output logic             n_o,
  output logic             z_o
);
  logic [63:0]      w64, m64, i64;
  logic [31:0]      top, mtop, fld_top, fld_u, fld_s, ins_top;
  logic [LEN_W-1:0] sh;
  logic [WIN_W-1:0] m40, i40;

  always_comb begin
    sh      = LEN_W'(FIELD_W) - len_i;
    w64     = {win_i, 24'b0} << bofs_i;
    top     = w64[63:32];
    mtop    = 32'hFFFF_FFFF << sh;
    fld_top = top & mtop;
    fld_u   = fld_top >> sh;
    fld_s   = 32'($signed(fld_top) >>> sh);
    ins_top = src_i << sh;
    m64     = {mtop, 32'b0} >> bofs_i;
    i64     = {ins_top, 32'b0} >> bofs_i;
    m40     = m64[63:24];
    i40     = i64[63:24];

    unique case (op_i)
      BF_INS:  win_o = (win_i & ~m40) | (i40 & m40);
      BF_CHG:  win_o = win_i ^ m40;
      BF_CLR:  win_o = win_i & ~m40;
      BF_SET:  win_o = win_i | m40;
      default: win_o = win_i;
    endcase

    unique case (op_i)
      BF_EXTS: res_o = fld_s;
      BF_INS:  res_o = ins_top >> sh;
      BF_FFO:  res_o = ofs_i + 32'((fld_u == 32'd0) ? len_i : lead_zeros(fld_top));
      default: res_o = fld_u;
    endcase

    n_o = (op_i == BF_INS) ? ins_top[31] : fld_top[31];
    z_o = (op_i == BF_INS) ? (ins_top == 32'd0) : (fld_top == 32'd0);
  end
endmodule

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit
  import bfu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [31:0]       bit_ofs,
  input  logic [31:0]       len_raw,
  input  logic [31:0]       src_val,
  output logic              busy,
  output logic              done,
  output logic [31:0]       result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack
);
  typedef enum logic [2:0] {S_IDLE, S_READ, S_CALC, S_WRITE, S_DONE} state_e;

  state_e           state_q;
  logic [2:0]       op_q, bofs_q, last_q, idx_q;
  logic [31:0]      ofs_q, src_q, res_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0] len_q;
  logic [WIN_W-1:0] win_q, wwin_q;
  logic             n_q, z_q;

  logic [ADDR_W-1:0] sc_addr;
  logic [2:0]        sc_bofs, sc_last;
  logic [LEN_W-1:0]  sc_len;
  logic [WIN_W-1:0]  alu_win;
  logic [31:0]       alu_res;
  logic              alu_n, alu_z;

  // Named events for the assertions
  logic ev_accept, ev_beat, ev_last_beat, ev_read_last;
  assign ev_accept    = (state_q == S_IDLE) && start;
  assign ev_beat      = mem_req && mem_ack;
  assign ev_last_beat = ev_beat && (idx_q == last_q);
  assign ev_read_last = ev_last_beat && (state_q == S_READ);

  bfu_span_calc #(.ADDR_W(ADDR_W)) u_span (
    .base_i(base_addr), .ofs_i(bit_ofs), .len_raw_i(len_raw),
    .first_addr_o(sc_addr), .bofs_o(sc_bofs), .len_o(sc_len), .last_o(sc_last)
  );

  bfu_field_alu u_alu (
    .op_i(op_q), .win_i(win_q), .bofs_i(bofs_q), .len_i(len_q),
    .src_i(src_q), .ofs_i(ofs_q),
    .win_o(alu_win), .res_o(alu_res), .n_o(alu_n), .z_o(alu_z)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q <= '0; bofs_q <= '0; last_q <= '0; idx_q <= '0;
      ofs_q <= '0; src_q <= '0; res_q <= '0; addr_q <= '0; len_q <= '0;
      win_q <= '0; wwin_q <= '0; n_q <= 1'b0; z_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          op_q <= op; ofs_q <= bit_ofs; src_q <= src_val;
          addr_q <= sc_addr; bofs_q <= sc_bofs; len_q <= sc_len; last_q <= sc_last;
          idx_q <= '0; win_q <= '0;
          state_q <= S_READ;
        end
        S_READ: if (mem_ack) begin
          win_q[(WIN_W - 1 - 8 * int'(idx_q)) -: 8] <= mem_rdata;
          if (idx_q == last_q) state_q <= S_CALC;
          else                 idx_q <= idx_q + 3'd1;
        end
        S_CALC: begin
          res_q <= alu_res; n_q <= alu_n; z_q <= alu_z; wwin_q <= alu_win;
          idx_q <= '0;
          state_q <= is_modify(op_q) ? S_WRITE : S_DONE;
        end
        S_WRITE: if (mem_ack) begin
          if (idx_q == last_q) state_q <= S_DONE;
          else                 idx_q <= idx_q + 3'd1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign result    = res_q;
  assign flag_n    = n_q;
  assign flag_z    = z_q;
  assign mem_req   = (state_q == S_READ) || (state_q == S_WRITE);
  assign mem_we    = (state_q == S_WRITE);
  assign mem_addr  = addr_q + ADDR_W'(idx_q);
  assign mem_wdata = wwin_q[(WIN_W - 1 - 8 * int'(idx_q)) -: 8];

  // R11: request and its attributes hold until acknowledged
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R11: done is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: the last read beat is followed by computation, never directly by a write
  assert_read_then_calc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read_last |=> !mem_req);

  // R6 / R7 / R8: writes only occur for modifying operations
  assert_write_only_modify_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> is_modify(op_q));

  // R3: span never exceeds five bytes
  assert_span_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> last_q <= 3'd4);

  // R8: find-first-one lands within [offset, offset + length]
  assert_ffo_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q == BF_FFO |-> (res_q - ofs_q) <= 32'(len_q));

  // R5: unsigned extract has nothing above the field length
  assert_extu_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q == BF_EXTU |-> (64'(res_q) >> len_q) == 64'd0);

  // R11: a new operation is only taken while idle
  assert_accept_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy && !done);
endmodule

// File: tb/tb_bitfield_mem_unit.sv
module tb_bitfield_mem_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk, rst_n, start;
  logic [2:0] op;
  logic [AW-1:0] base_addr;
  logic [31:0] bit_ofs, len_raw, src_val, result;
  logic busy, done, flag_n, flag_z, mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  bitfield_mem_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_addr(base_addr),
    .bit_ofs(bit_ofs), .len_raw(len_raw), .src_val(src_val), .busy(busy), .done(done),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0] mem [64];
  logic [7:0] ref_mem [64];

  // Memory model: one-cycle acknowledge, data registered with it
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= 8'h00;
      for (int i = 0; i < 64; i++) mem[i] <= 8'((i * 37 + 5) & 255);
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[5:0]];
        if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
      end
    end
  end

  typedef struct {
    logic [31:0] res;
    logic n, z;
    int rd, wr;
    string tag;
  } exp_t;
  exp_t sb[$];

  int n_checks = 0, n_fail = 0;

  task automatic chk(input string name, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", name, act, exp);
    end
  endtask

  // Monitor: counts memory beats and compares results at done
  int rd_cnt = 0, wr_cnt = 0, order_bad = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ack) begin
        if (mem_we) wr_cnt++;
        else begin
          rd_cnt++;
          if (wr_cnt != 0) order_bad++;
        end
      end
      if (done) begin
        if (sb.size() == 0) chk("R11 unexpected done", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " result"}, result, e.res);
          chk({e.tag, " R9 N flag"}, 32'(flag_n), 32'(e.n));
          chk({e.tag, " R10 Z flag"}, 32'(flag_z), 32'(e.z));
          chk({e.tag, " R3 bytes read"}, 32'(rd_cnt), 32'(e.rd));
          chk({e.tag, " R11 bytes written"}, 32'(wr_cnt), 32'(e.wr));
          chk({e.tag, " R11 reads before writes"}, 32'(order_bad), 32'd0);
        end
        rd_cnt = 0; wr_cnt = 0; order_bad = 0;
      end
    end
  end

  // Driver: bit-by-bit reference model, then issue the request
  task automatic run_op(input int o, input int base, input logic [31:0] ofs,
                        input logic [31:0] lraw, input logic [31:0] src, input string tag);
    exp_t e;
    int len, first_one, mism;
    logic [31:0] old;
    longint fb, lb;
    len = (lraw[4:0] == 5'd0) ? 32 : int'(lraw[4:0]);
    old = 0; first_one = -1;
    for (int i = 0; i < len; i++) begin
      longint bp;
      int bi, bn;
      logic b, nb;
      bp = longint'($signed(ofs)) + longint'(i);
      bi = int'((longint'(base) + (bp >>> 3)) & 63);
      bn = 7 - int'(bp & 7);
      b = ref_mem[bi][bn];
      old = {old[30:0], b};
      if (b && first_one < 0) first_one = i;
      case (o)
        2: nb = src[len - 1 - i];
        3: nb = ~b;
        4: nb = 1'b0;
        5: nb = 1'b1;
        default: nb = b;
      endcase
      ref_mem[bi][bn] = nb;
    end
    e.tag = tag;
    case (o)
      1: e.res = (len < 32 && old[len - 1]) ? (old | (32'hFFFF_FFFF << len)) : old;
      2: e.res = (len == 32) ? src : (src & ~(32'hFFFF_FFFF << len));
      6: e.res = ofs + 32'((first_one < 0) ? len : first_one);
      default: e.res = old;
    endcase
    e.n = (o == 2) ? src[len - 1] : old[len - 1];
    e.z = (o == 2) ? (((len == 32) ? src : (src & ~(32'hFFFF_FFFF << len))) == 0) : (old == 0);
    fb = longint'($signed(ofs)) >>> 3;
    lb = (longint'($signed(ofs)) + longint'(len) - 1) >>> 3;
    e.rd = int'(lb - fb + 1);
    e.wr = (o >= 2 && o <= 5) ? e.rd : 0;
    sb.push_back(e);

    @(negedge clk);
    op = 3'(o); base_addr = AW'(base); bit_ofs = ofs; len_raw = lraw; src_val = src;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    chk({tag, " R11 idle after done"}, 32'(busy), 32'd0);
    mism = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== ref_mem[i]) mism++;
    chk({tag, " R6 R7 memory image"}, 32'(mism), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = 8'((i * 37 + 5) & 255);
    rst_n = 1'b0; start = 1'b0; op = 3'd0; base_addr = '0;
    bit_ofs = 0; len_raw = 0; src_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset busy", 32'(busy), 32'd0);
    chk("R11 reset done", 32'(done), 32'd0);
    chk("R11 reset mem_req", 32'(mem_req), 32'd0);

    run_op(0, 16, 32'd0,         32'd8,  32'd0,        "R4 R5 extu byte");
    run_op(1, 16, 32'd4,         32'd12, 32'd0,        "R5 exts two bytes");
    run_op(0, 20, -32'sd3,       32'd5,  32'd0,        "R2 extu negative offset");
    run_op(1, 24, 32'd7,         32'd0,  32'd0,        "R1 R3 exts full word five bytes");
    run_op(2, 12, 32'd13,        32'd9,  32'h0000_01A5, "R6 insert");
    run_op(3, 30, -32'sd9,       32'd20, 32'd0,        "R7 R2 change");
    run_op(4, 8,  32'd30,        32'd3,  32'd0,        "R7 clear");
    run_op(5, 40, 32'd5,         32'd0,  32'd0,        "R7 R1 set full word");
    run_op(6, 12, 32'd3,         32'd10, 32'd0,        "R8 ffo nonzero");
    run_op(4, 48, 32'd2,         32'd11, 32'd0,        "R7 clear for ffo");
    run_op(6, 48, 32'd2,         32'd11, 32'd0,        "R8 ffo zero field");
    run_op(2, 32, 32'd6,         32'd4,  32'hFFFF_FFF0, "R6 R10 insert zeros");
    run_op(0, 20, 32'd1,         32'd37, 32'd0,        "R1 length upper bits ignored");
    run_op(6, 36, -32'sd12,      32'd0,  32'd0,        "R8 R2 ffo negative offset");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule